// File: doc/BRIEF.md
# DMA Stream Interrupt Status Unit

This block collects per-stream status for a four-stream DMA engine and presents it as one read-only 32-bit status word. Each stream has three indicators. A completion flag is sticky and records that a full packet reached its destination. An error flag is sticky and records that a transfer was aborted by a bus error. An activity flag is live and shows that a transfer is in progress. The transfer engines feed the block with single-cycle event pulses and a busy level for each stream.

Software clears the sticky flags through a separate clear register. That register works write-1-to-clear and uses the same bit positions as the status word. Writes aimed at the status word itself are ignored. A single interrupt line is raised while any sticky flag is set.

When a stream reports a bus error while its enable bit is on, the block emits a one-cycle enable-clear strobe for that stream. The control register uses the strobe to drop the enable, and the stream stays off until software sets the enable again.

Top module: `dma_irq_status`

## Requirements
- R1: After reset the status word, `irq` and `en_clr` are all 0.
- R2: A `done_pulse[i]` high at a clock edge sets status bit i (the completion flags occupy bits 3:0) from that edge on. The bit stays set until it is cleared.
- R3: An `err_pulse[i]` high at a clock edge sets status bit 4+i (the error flags occupy bits 7:4) from that edge on. The bit stays set until it is cleared.
- R4: `en_clr[i]` is high for exactly the one cycle after an edge at which both `err_pulse[i]` and `stream_en[i]` were high. It is low if the stream was not enabled.
- R5: A write with `wr_en`=1 and `wr_sel`=1 clears every completion or error flag whose `wr_data` bit at the same position (bits 7:0) is 1. Flags at positions written 0 keep their value.
- R6: If a set pulse and a clear write hit the same flag at the same edge, the flag ends up set.
- R7: A write with `wr_sel`=0, which addresses the status word, changes no flag.
- R8: Status bits 11:8 equal `busy[3:0]` as sampled at the previous clock edge.
- R9: Status bits 31:12 always read 0.
- R10: `irq` is 1 exactly when any of status bits 7:0 is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| done_pulse | input | 4 | Per-stream packet-complete event |
| err_pulse | input | 4 | Per-stream bus-error abort event |
| busy | input | 4 | Per-stream transfer-in-progress level |
| stream_en | input | 4 | Current per-stream enable bits |
| wr_en | input | 1 | Bus write strobe |
| wr_sel | input | 1 | 1 = clear register, 0 = status word |
| wr_data | input | 8 | Flag-bearing low byte of write data |
| status | output | 32 | Status word |
| irq | output | 1 | Combined interrupt |
| en_clr | output | 4 | One-cycle enable-clear strobe per stream |

## Verification
Flags, activity bits and enable-clear strobes are registered. Each of them shows its new value one edge after the stimulus. `irq` follows the flags with no added delay. The bench drives inputs on the falling edge, lets one rising edge pass, and samples on the next falling edge. It then removes the stimulus and samples once more to check stickiness and the single-cycle strobe width.

// File: rtl/dma_irq_status.sv
module dma_irq_status #(
  parameter int NSTREAM = 4,
  parameter int WORD_W  = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [NSTREAM-1:0]     done_pulse,
  input  logic [NSTREAM-1:0]     err_pulse,
  input  logic [NSTREAM-1:0]     busy,
  input  logic [NSTREAM-1:0]     stream_en,
  input  logic                   wr_en,
  input  logic                   wr_sel,
  input  logic [2*NSTREAM-1:0]   wr_data,
  output logic [WORD_W-1:0]      status,
  output logic                   irq,
  output logic [NSTREAM-1:0]     en_clr
);
  localparam int FLAG_W = 2 * NSTREAM;
  localparam int USED_W = 3 * NSTREAM;
  localparam int PAD_W  = WORD_W - USED_W;

  logic [NSTREAM-1:0] done_q, err_q, act_q, kill_q;

  wire                clr_hit  = wr_en & wr_sel;
  wire [NSTREAM-1:0]  done_clr = clr_hit ? wr_data[NSTREAM-1:0]      : '0;
  wire [NSTREAM-1:0]  err_clr  = clr_hit ? wr_data[FLAG_W-1:NSTREAM] : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done_q <= '0;
      err_q  <= '0;
      act_q  <= '0;
      kill_q <= '0;
    end else begin
      done_q <= (done_q & ~done_clr) | done_pulse;
      err_q  <= (err_q  & ~err_clr)  | err_pulse;
      act_q  <= busy;
      kill_q <= err_pulse & stream_en;
    end
  end

  assign status = {{PAD_W{1'b0}}, act_q, err_q, done_q};
  assign irq    = |{err_q, done_q};
  assign en_clr = kill_q;
endmodule

module dma_irq_status_chk #(
  parameter int NSTREAM = 4,
  parameter int WORD_W  = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NSTREAM-1:0]   done_pulse,
  input logic [NSTREAM-1:0]   err_pulse,
  input logic [NSTREAM-1:0]   busy,
  input logic [NSTREAM-1:0]   stream_en,
  input logic                 wr_en,
  input logic                 wr_sel,
  input logic [WORD_W-1:0]    status,
  input logic                 irq,
  input logic [NSTREAM-1:0]   en_clr
);
  logic armed;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) armed <= 1'b0; else armed <= 1'b1;

  p_reserved_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    status[WORD_W-1:3*NSTREAM] == '0);

  p_irq_or_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq == (status[2*NSTREAM-1:0] != '0));

  p_act_delay_r8: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> status[3*NSTREAM-1:2*NSTREAM] == $past(busy));

  p_done_set_r2: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (done_pulse != '0) |=>
      (status[NSTREAM-1:0] & $past(done_pulse)) == $past(done_pulse));

  p_err_set_r3: assert property (@(posedge clk) disable iff (!rst_n)
    armed && (err_pulse != '0) |=>
      (status[2*NSTREAM-1:NSTREAM] & $past(err_pulse)) == $past(err_pulse));

  p_strobe_r4: assert property (@(posedge clk) disable iff (!rst_n)
    armed |=> en_clr == $past(err_pulse & stream_en));

  p_status_write_ignored_r7: assert property (@(posedge clk) disable iff (!rst_n)
    armed && wr_en && !wr_sel && done_pulse == '0 && err_pulse == '0
      |=> $stable(status[2*NSTREAM-1:0]));
endmodule

bind dma_irq_status dma_irq_status_chk #(.NSTREAM(NSTREAM), .WORD_W(WORD_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .err_pulse(err_pulse),
  .busy(busy), .stream_en(stream_en), .wr_en(wr_en), .wr_sel(wr_sel),
  .status(status), .irq(irq), .en_clr(en_clr));

// File: tb/dma_irq_status_bench.sv
module dma_irq_status_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  done_pulse = '0, err_pulse = '0, busy = '0, stream_en = '0;
  logic        wr_en = 1'b0, wr_sel = 1'b0;
  logic [7:0]  wr_data = '0;
  logic [31:0] status;
  logic        irq;
  logic [3:0]  en_clr;
  int          checks = 0, errors = 0;

  always #10 clk = ~clk;

  dma_irq_status u_dma_irq_status (
    .clk(clk), .rst_n(rst_n), .done_pulse(done_pulse), .err_pulse(err_pulse),
    .busy(busy), .stream_en(stream_en), .wr_en(wr_en), .wr_sel(wr_sel),
    .wr_data(wr_data), .status(status), .irq(irq), .en_clr(en_clr));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle();
    done_pulse = '0; err_pulse = '0; wr_en = 1'b0; wr_sel = 1'b0; wr_data = '0;
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic clear_all();
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'hFF;
    step(); idle();
  endtask

  task automatic t_reset();
    chk("R1 status", status, 32'h0);
    chk("R1 irq", {31'h0, irq}, 32'h0);
    chk("R1 en_clr", {28'h0, en_clr}, 32'h0);
  endtask

  task automatic t_done();
    for (int i = 0; i < 4; i++) begin
      done_pulse = 4'b1 << i; step(); idle();
      chk("R2 done set", status, 32'h1 << i);
      chk("R10 irq on", {31'h0, irq}, 32'h1);
      step();
      chk("R2 done sticky", status, 32'h1 << i);
      clear_all();
      chk("R10 irq off", {31'h0, irq}, 32'h0);
    end
  endtask

  task automatic t_err();
    stream_en = 4'b0101;
    err_pulse = 4'b0011; step(); idle();
    chk("R3 err set", status, 32'h30);
    chk("R4 strobe enabled only", {28'h0, en_clr}, 32'h1);
    step();
    chk("R4 strobe one cycle", {28'h0, en_clr}, 32'h0);
    chk("R3 err sticky", status, 32'h30);
    clear_all();
    stream_en = '0;
  endtask

  task automatic t_w1c();
    done_pulse = 4'b1111; err_pulse = 4'b1111; step(); idle();
    chk("R2 R3 all set", status, 32'hFF);
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'hA5; step(); idle();
    chk("R5 partial clear", status, 32'h5A);
    chk("R10 irq partial", {31'h0, irq}, 32'h1);
    clear_all();
    chk("R5 full clear", status, 32'h0);
  endtask

  task automatic t_set_wins();
    done_pulse = 4'b0100; err_pulse = 4'b1000;
    wr_en = 1'b1; wr_sel = 1'b1; wr_data = 8'hFF; step(); idle();
    chk("R6 set beats clear", status, 32'h84);
    clear_all();
  endtask

  task automatic t_status_write();
    done_pulse = 4'b0010; step(); idle();
    wr_en = 1'b1; wr_sel = 1'b0; wr_data = 8'hFF; step(); idle();
    chk("R7 status write ignored", status, 32'h2);
    clear_all();
  endtask

  task automatic t_activity();
    busy = 4'b1010; step();
    chk("R8 active mirror", status, 32'hA00);
    busy = 4'b0110;
    chk("R8 no early change", status, 32'hA00);
    step();
    chk("R8 active follow", status, 32'h600);
    chk("R10 busy no irq", {31'h0, irq}, 32'h0);
    chk("R9 reserved zero", status & 32'hFFFFF000, 32'h0);
    busy = '0; step();
    chk("R8 active off", status, 32'h0);
  endtask

  initial begin
    fork
      begin
        repeat (3) step();
        t_reset();
        rst_n = 1'b1;
        step();
        t_reset();
        t_done();
        t_err();
        t_w1c();
        t_set_wins();
        t_status_write();
        t_activity();
      end
      begin
        repeat (5000) @(posedge clk);
        checks++; errors++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule